// File: doc/BRIEF.md
# Byte-Lane Register Window Adapter

This block connects a 128-byte, byte-addressed host I/O window to register targets that can only be read and written as whole 32-bit words. The host issues reads and writes of one, two or four bytes. The adapter decodes the address into one of three targets: a sixteen-word core register bank, an eight-word DMA register bank and a single bus-control word. It then performs a whole-word operation on the selected target.

For a write narrower than a word, the adapter first reads the current word from the target. It replaces only the bytes the host wrote and then writes the whole word back, so the targets never see byte enables. For a read, the adapter selects the requested bytes from the word and returns them right-justified, with zeros above them. Offsets that fall in no region read as zero and ignore writes. A request whose bytes would run past a word boundary is refused. While an access is in progress the adapter raises a busy flag, and the host must hold off until it drops.

Top module: `regwin_adapter`

## Requirements
- R1: Offsets 0x00 to 0x3F select the core bank (`core_sel`), with word index `core_idx` = offset bits [5:2].
- R2: Offsets 0x40 to 0x5F select the DMA bank (`dma_sel`), with word index `dma_idx` = bits [4:2] of (offset minus 0x40).
- R3: The bus-control word (`ctrl_sel`) is selected only when the offset is exactly 0x70. Offsets 0x71 to 0x73 behave as unmapped.
- R4: A read from an unmapped offset (0x60 to 0x6F, 0x71 to 0x7F) returns zero, and a write to one selects no target and changes nothing.
- R5: The size code `host_size` gives the access width: 0 is one byte, 1 is two bytes, 2 is four bytes. Code 3 is refused in the same way as R8.
- R6: A one- or two-byte write puts its data, taken from the low bytes of `host_wdata`, into the lanes starting at byte `addr[1:0]`, where byte k is `wdata[8k+7:8k]`. The other bytes of the target word keep their values, and the result is written as one whole word at the word index of R1 to R3.
- R7: A read returns the target word shifted right by 8 × `addr[1:0]` and masked to the access width. `host_rvalid` is high for exactly one cycle, and `host_rdata` is valid during that cycle.
- R8: A request with `addr[1:0]` + width greater than 4 is refused. `host_err` pulses for one cycle right after the request, no target is selected, `host_rvalid` stays low and `host_busy` stays low.
- R9: When a read or a four-byte write is accepted, `host_busy` is high for one cycle. When a one- or two-byte write is accepted, `host_busy` is high for two cycles: the first reads the old word and the second writes the merged word. A read result appears in the cycle after `host_busy` drops.
- R10: A request presented while `host_busy` is high is ignored and has no effect on any target.
- R11: During reset and after it, until the first request, `host_busy`, `host_rvalid`, `host_err`, all target selects and `tgt_we` are low.
- R12: At most one target select is high in any cycle, and `tgt_we` is high only together with a select while `host_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request strobe, taken when host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Byte offset in the window |
| host_size | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = refused |
| host_wdata | input | 32 | Write data, right-justified |
| host_busy | output | 1 | Access in progress |
| host_rvalid | output | 1 | Read result valid (one cycle) |
| host_rdata | output | 32 | Read result, right-justified, zero-extended |
| host_err | output | 1 | Request refused (one-cycle pulse) |
| core_sel | output | 1 | Core bank access |
| core_idx | output | 4 | Core bank word index |
| core_rdata | input | 32 | Core bank word at core_idx |
| dma_sel | output | 1 | DMA bank access |
| dma_idx | output | 3 | DMA bank word index |
| dma_rdata | input | 32 | DMA bank word at dma_idx |
| ctrl_sel | output | 1 | Bus-control word access |
| ctrl_rdata | input | 32 | Bus-control word |
| tgt_we | output | 1 | Write strobe to the selected target |
| tgt_wdata | output | 32 | Whole-word write data to targets |

## Verification
The bench drives partial writes at every byte lane and then reads the word back in each width. A merge that put the data in the wrong lanes, or that did not keep the untouched bytes, would leave target words that differ from the model. It probes the edges of the address decode: the last core word, the first and last DMA words, the gap from 0x60 to 0x6F, and the offsets 0x71 to 0x73 that lie next to the control word. A decode that matched on the aligned word would write the control register through 0x72 and return its bytes at 0x71. It also covers accesses that run past a word boundary and the reserved size code, which a flawed design would pass on as a truncated or wrapped access. Finally, it presents a second request while a merge is in flight, which a design that sampled requests while busy would carry out as an unwanted write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CORE = 2'd1,
    RGN_DMA  = 2'd2,
    RGN_CTRL = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } state_e;

  // number of bytes covered by a size code; the widest code means a full word
  function automatic int unsigned sz_bytes(input logic [1:0] code, input int unsigned word_bytes);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return word_bytes;
    endcase
  endfunction

endpackage

// File: rtl/regwin_rstsync.sv
module regwin_rstsync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int NBYTES    = 4,
  parameter int CORE_BASE = 0,
  parameter int CORE_SPAN = 64,
  parameter int DMA_BASE  = 64,
  parameter int DMA_SPAN  = 32,
  parameter int CTRL_OFS  = 112,
  parameter int OFS_W     = $clog2(NBYTES),
  parameter int CORE_IDX_W = $clog2(CORE_SPAN / NBYTES),
  parameter int DMA_IDX_W  = $clog2(DMA_SPAN / NBYTES)
) (
  input  logic [ADDR_W-1:0]     addr,
  output region_e               region,
  output logic [CORE_IDX_W-1:0] core_idx,
  output logic [DMA_IDX_W-1:0]  dma_idx
);

  localparam logic [ADDR_W:0]   CORE_LO  = (ADDR_W+1)'(CORE_BASE);
  localparam logic [ADDR_W:0]   CORE_LEN = (ADDR_W+1)'(CORE_SPAN);
  localparam logic [ADDR_W:0]   DMA_LO   = (ADDR_W+1)'(DMA_BASE);
  localparam logic [ADDR_W:0]   DMA_LEN  = (ADDR_W+1)'(DMA_SPAN);
  localparam logic [ADDR_W-1:0] CTRL_AT  = ADDR_W'(CTRL_OFS);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] core_off;
  logic [ADDR_W:0] dma_off;
  logic            in_core;
  logic            in_dma;
  logic            in_ctrl;

  // offsets wrap when the address is below a base, so one compare checks both ends
  assign addr_x   = {1'b0, addr};
  assign core_off = addr_x - CORE_LO;
  assign dma_off  = addr_x - DMA_LO;
  assign in_core  = core_off < CORE_LEN;
  assign in_dma   = dma_off < DMA_LEN;
  assign in_ctrl  = addr == CTRL_AT;

  assign core_idx = core_off[CORE_IDX_W+OFS_W-1:OFS_W];
  assign dma_idx  = dma_off[DMA_IDX_W+OFS_W-1:OFS_W];

  always_comb begin
    if (in_core) begin
      region = RGN_CORE;
    end else if (in_dma) begin
      region = RGN_DMA;
    end else if (in_ctrl) begin
      region = RGN_CTRL;
    end else begin
      region = RGN_NONE;
    end
  end

endmodule

// File: rtl/regwin_lanes.sv
module regwin_lanes
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NBYTES = DATA_W / 8,
  parameter int OFS_W  = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] cur_word,
  input  logic [DATA_W-1:0] new_data,
  input  logic [OFS_W-1:0]  lane_ofs,
  input  logic [1:0]        size_code,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] extracted
);

  logic [OFS_W:0]    lane_cnt;
  logic [OFS_W:0]    ofs_x;
  logic [OFS_W:0]    lane_end;
  logic [DATA_W-1:0] data_sh;
  logic [DATA_W-1:0] word_sh;

  assign lane_cnt = (OFS_W+1)'(sz_bytes(size_code, NBYTES));
  assign ofs_x    = {1'b0, lane_ofs};
  assign lane_end = ofs_x + lane_cnt;
  assign data_sh  = new_data << {lane_ofs, 3'b000};
  assign word_sh  = cur_word >> {lane_ofs, 3'b000};

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    localparam logic [OFS_W:0] LANE = (OFS_W+1)'(b);
    logic hit;
    assign hit = (LANE >= ofs_x) && (LANE < lane_end);
    assign merged[8*b +: 8]    = hit ? data_sh[8*b +: 8] : cur_word[8*b +: 8];
    assign extracted[8*b +: 8] = (LANE < lane_cnt) ? word_sh[8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/regwin_fsm.sv
module regwin_fsm
  import regwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic host_we,
  input  logic req_ok,
  input  logic req_narrow,
  output logic busy,
  output logic accept,
  output logic reject,
  output logic st_fetch,
  output logic st_write,
  output logic st_read
);

  state_e state_q;
  state_e state_d;
  logic   idle;

  assign idle   = state_q == ST_IDLE;
  assign accept = host_req && idle && req_ok;
  assign reject = host_req && idle && !req_ok;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!host_we) begin
            state_d = ST_READ;
          end else if (req_narrow) begin
            state_d = ST_FETCH;
          end else begin
            state_d = ST_WRITE;
          end
        end
      end
      ST_FETCH: state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      ST_READ:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy     = !idle;
  assign st_fetch = state_q == ST_FETCH;
  assign st_write = state_q == ST_WRITE;
  assign st_read  = state_q == ST_READ;

endmodule

// File: rtl/regwin_adapter.sv
module regwin_adapter
  import regwin_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int CORE_BASE = 0,
  parameter int CORE_SPAN = 64,
  parameter int DMA_BASE  = 64,
  parameter int DMA_SPAN  = 32,
  parameter int CTRL_OFS  = 112,
  parameter int NBYTES     = DATA_W / 8,
  parameter int OFS_W      = $clog2(NBYTES),
  parameter int CORE_IDX_W = $clog2(CORE_SPAN / NBYTES),
  parameter int DMA_IDX_W  = $clog2(DMA_SPAN / NBYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_req,
  input  logic                  host_we,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [1:0]            host_size,
  input  logic [DATA_W-1:0]     host_wdata,
  output logic                  host_busy,
  output logic                  host_rvalid,
  output logic [DATA_W-1:0]     host_rdata,
  output logic                  host_err,
  output logic                  core_sel,
  output logic [CORE_IDX_W-1:0] core_idx,
  input  logic [DATA_W-1:0]     core_rdata,
  output logic                  dma_sel,
  output logic [DMA_IDX_W-1:0]  dma_idx,
  input  logic [DATA_W-1:0]     dma_rdata,
  output logic                  ctrl_sel,
  input  logic [DATA_W-1:0]     ctrl_rdata,
  output logic                  tgt_we,
  output logic [DATA_W-1:0]     tgt_wdata
);

  logic rst_n_s;

  regwin_rstsync u_rstsync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // request qualification at the host edge
  int unsigned span_end;
  logic        req_ok;
  logic        req_narrow;

  always_comb begin
    span_end   = 32'(host_addr[OFS_W-1:0]) + sz_bytes(host_size, NBYTES);
    req_ok     = (host_size != SZ_RSVD) && (span_end <= NBYTES);
    req_narrow = host_size != SZ_WORD;
  end

  logic busy;
  logic accept;
  logic reject;
  logic st_fetch;
  logic st_write;
  logic st_read;

  regwin_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .host_req   (host_req),
    .host_we    (host_we),
    .req_ok     (req_ok),
    .req_narrow (req_narrow),
    .busy       (busy),
    .accept     (accept),
    .reject     (reject),
    .st_fetch   (st_fetch),
    .st_write   (st_write),
    .st_read    (st_read)
  );

  // captured request
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wbuf_q;
  logic [DATA_W-1:0] wbuf_d;
  logic              wbuf_en;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              err_q;

  // decode of the captured address
  region_e               region;
  logic [CORE_IDX_W-1:0] core_idx_w;
  logic [DMA_IDX_W-1:0]  dma_idx_w;

  regwin_decode #(
    .ADDR_W    (ADDR_W),
    .NBYTES    (NBYTES),
    .CORE_BASE (CORE_BASE),
    .CORE_SPAN (CORE_SPAN),
    .DMA_BASE  (DMA_BASE),
    .DMA_SPAN  (DMA_SPAN),
    .CTRL_OFS  (CTRL_OFS)
  ) u_decode (
    .addr     (addr_q),
    .region   (region),
    .core_idx (core_idx_w),
    .dma_idx  (dma_idx_w)
  );

  // word returned by the selected target, zero where nothing is mapped
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    case (region)
      RGN_CORE: rd_word = core_rdata;
      RGN_DMA:  rd_word = dma_rdata;
      RGN_CTRL: rd_word = ctrl_rdata;
      default:  rd_word = '0;
    endcase
  end

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] extracted;

  regwin_lanes #(
    .DATA_W (DATA_W)
  ) u_lanes (
    .cur_word  (rd_word),
    .new_data  (wbuf_q),
    .lane_ofs  (addr_q[OFS_W-1:0]),
    .size_code (size_q),
    .merged    (merged),
    .extracted (extracted)
  );

  // next-state for the write buffer: raw data on accept, merged word after the fetch
  always_comb begin
    wbuf_en = accept || st_fetch;
    wbuf_d  = st_fetch ? merged : host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q <= '0;
      size_q <= '0;
    end else if (accept) begin
      addr_q <= host_addr;
      size_q <= host_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wbuf_q <= '0;
    end else if (wbuf_en) begin
      wbuf_q <= wbuf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q <= '0;
    end else if (st_read) begin
      rdata_q <= extracted;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= st_read;
      err_q    <= reject;
    end
  end

  // target side
  logic tgt_active;

  assign tgt_active = st_fetch || st_write || st_read;
  assign core_sel   = tgt_active && (region == RGN_CORE);
  assign dma_sel    = tgt_active && (region == RGN_DMA);
  assign ctrl_sel   = tgt_active && (region == RGN_CTRL);
  assign core_idx   = core_idx_w;
  assign dma_idx    = dma_idx_w;
  assign tgt_we     = st_write && (region != RGN_NONE);
  assign tgt_wdata  = wbuf_q;

  assign host_busy   = busy;
  assign host_rvalid = rvalid_q;
  assign host_rdata  = rdata_q;
  assign host_err    = err_q;

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_req,
  input logic       host_we,
  input logic [1:0] host_addr_lo,
  input logic [1:0] host_size,
  input logic       host_busy,
  input logic       host_rvalid,
  input logic       host_err,
  input logic       core_sel,
  input logic       dma_sel,
  input logic       ctrl_sel,
  input logic       tgt_we
);

  logic any_sel;
  assign any_sel = core_sel || dma_sel || ctrl_sel;

  // R12
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_sel, dma_sel, ctrl_sel}));

  // R12
  we_with_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we |-> (host_busy && any_sel));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_busy |-> (!any_sel && !tgt_we));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> (!host_busy && !host_rvalid && !any_sel));

  // R5
  rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_busy && host_size == 2'd3) |=> (host_err && !host_busy));

  // R7
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> ($past(host_busy) && !$past(tgt_we) && !host_busy));

  // R9
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_busy && !host_we && host_size == 2'd2 && host_addr_lo == 2'b00)
      |=> (host_busy && !host_rvalid) ##1 (!host_busy && host_rvalid));

  // R9
  narrow_write_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_busy && host_we && host_size == 2'd0)
      |=> host_busy ##1 host_busy ##1 !host_busy);

endmodule

bind regwin_adapter regwin_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .host_req     (host_req),
  .host_we      (host_we),
  .host_addr_lo (host_addr[1:0]),
  .host_size    (host_size),
  .host_busy    (host_busy),
  .host_rvalid  (host_rvalid),
  .host_err     (host_err),
  .core_sel     (core_sel),
  .dma_sel      (dma_sel),
  .ctrl_sel     (ctrl_sel),
  .tgt_we       (tgt_we)
);

// File: tb/regwin_adapter_tb_top.sv
module regwin_adapter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req;
  logic        host_we;
  logic [6:0]  host_addr;
  logic [1:0]  host_size;
  logic [31:0] host_wdata;
  logic        host_busy;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        host_err;
  logic        core_sel;
  logic [3:0]  core_idx;
  logic [31:0] core_rdata;
  logic        dma_sel;
  logic [2:0]  dma_idx;
  logic [31:0] dma_rdata;
  logic        ctrl_sel;
  logic [31:0] ctrl_rdata;
  logic        tgt_we;
  logic [31:0] tgt_wdata;

  // target storage driven by the adapter, and the bench's own expectation of it
  logic [31:0] core_m [16];
  logic [31:0] dma_m  [8];
  logic [31:0] ctrl_m;
  logic [31:0] exp_core [16];
  logic [31:0] exp_dma  [8];
  logic [31:0] exp_ctrl;
  logic        init_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_adapter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_size   (host_size),
    .host_wdata  (host_wdata),
    .host_busy   (host_busy),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .host_err    (host_err),
    .core_sel    (core_sel),
    .core_idx    (core_idx),
    .core_rdata  (core_rdata),
    .dma_sel     (dma_sel),
    .dma_idx     (dma_idx),
    .dma_rdata   (dma_rdata),
    .ctrl_sel    (ctrl_sel),
    .ctrl_rdata  (ctrl_rdata),
    .tgt_we      (tgt_we),
    .tgt_wdata   (tgt_wdata)
  );

  function automatic logic [31:0] pat(int k);
    return 32'h1F2E3D4C ^ (32'(k) * 32'h01030507);
  endfunction

  assign core_rdata = core_m[core_idx];
  assign dma_rdata  = dma_m[dma_idx];
  assign ctrl_rdata = ctrl_m;

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 16; i++) core_m[i] <= pat(i);
      for (int i = 0; i < 8; i++)  dma_m[i]  <= pat(16 + i);
      ctrl_m <= pat(24);
    end else if (tgt_we) begin
      if (core_sel) core_m[core_idx] <= tgt_wdata;
      if (dma_sel)  dma_m[dma_idx]   <= tgt_wdata;
      if (ctrl_sel) ctrl_m           <= tgt_wdata;
    end
  end

  // ---------------- behavioural model ----------------
  function automatic int width_of(int code);
    case (code)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mdl_word(int a);
    if (a < 64)        return exp_core[a / 4];
    else if (a < 96)   return exp_dma[(a - 64) / 4];
    else if (a == 112) return exp_ctrl;
    else               return 32'h0;
  endfunction

  function automatic logic [31:0] width_mask(int n);
    if (n >= 4) return 32'hFFFF_FFFF;
    return (32'h1 << (8 * n)) - 32'h1;
  endfunction

  task automatic mdl_write(int a, int n, logic [31:0] d);
    logic [31:0] w;
    w = mdl_word(a);
    for (int b = 0; b < n; b++) w[8 * ((a % 4) + b) +: 8] = d[8 * b +: 8];
    if (a < 64)        exp_core[a / 4] = w;
    else if (a < 96)   exp_dma[(a - 64) / 4] = w;
    else if (a == 112) exp_ctrl = w;
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_mems(string tag);
    bit          ok = 1'b1;
    logic [31:0] a_v = '0;
    logic [31:0] e_v = '0;
    for (int i = 0; i < 16; i++)
      if (ok && core_m[i] !== exp_core[i]) begin ok = 1'b0; a_v = core_m[i]; e_v = exp_core[i]; end
    for (int i = 0; i < 8; i++)
      if (ok && dma_m[i] !== exp_dma[i]) begin ok = 1'b0; a_v = dma_m[i]; e_v = exp_dma[i]; end
    if (ok && ctrl_m !== exp_ctrl) begin ok = 1'b0; a_v = ctrl_m; e_v = exp_ctrl; end
    check(ok, tag, "target contents", a_v, e_v);
  endtask

  function automatic string region_tag(int a);
    if (a < 64)                 return "R1";
    else if (a < 96)            return "R2";
    else if (a >= 112 && a < 116) return "R3";
    else                        return "R4";
  endfunction

  // one host access, starting and ending just after a falling edge
  task automatic access(bit we, int a, int code, logic [31:0] d, string tag);
    int          n;
    bit          rej;
    int          lat;
    logic [31:0] exp_v;
    n   = width_of(code);
    rej = (n == 0) || ((a % 4) + n > 4);
    host_req   = 1'b1;
    host_we    = we;
    host_addr  = 7'(a);
    host_size  = 2'(code);
    host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    if (rej) begin
      check(host_err === 1'b1 && host_busy === 1'b0 && host_rvalid === 1'b0,
            (code == 3) ? "R5" : "R8", "refusal flags {err,busy,rvalid}",
            {29'b0, host_err, host_busy, host_rvalid}, 32'h4);
      @(negedge clk);
      check(host_err === 1'b0, "R8", "err pulse width", {31'b0, host_err}, 32'h0);
      check_mems((code == 3) ? "R5" : "R8");
    end else begin
      lat = (we && n < 4) ? 2 : 1;
      for (int k = 0; k < lat; k++) begin
        check(host_busy === 1'b1, "R9", "busy during access", {31'b0, host_busy}, 32'h1);
        @(negedge clk);
      end
      check(host_busy === 1'b0 && host_err === 1'b0, "R9", "busy/err after access",
            {30'b0, host_busy, host_err}, 32'h0);
      if (!we) begin
        exp_v = (mdl_word(a) >> (8 * (a % 4))) & width_mask(n);
        check(host_rvalid === 1'b1, "R7", "rvalid", {31'b0, host_rvalid}, 32'h1);
        check(host_rdata === exp_v, {tag, " R7"}, "read data", host_rdata, exp_v);
      end else begin
        mdl_write(a, n, d);
        check_mems(tag);
      end
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int a;
    int r;
    int code;
    bit we;
    host_req   = 1'b0;
    host_we    = 1'b0;
    host_addr  = '0;
    host_size  = '0;
    host_wdata = '0;
    init_req   = 1'b1;
    rst_n      = 1'b0;
    for (int i = 0; i < 16; i++) exp_core[i] = pat(i);
    for (int i = 0; i < 8; i++)  exp_dma[i]  = pat(16 + i);
    exp_ctrl = pat(24);

    repeat (3) @(negedge clk);
    // R11 reset state
    check({host_busy, host_rvalid, host_err, core_sel, dma_sel, ctrl_sel, tgt_we} === 7'b0,
          "R11", "outputs in reset",
          {25'b0, host_busy, host_rvalid, host_err, core_sel, dma_sel, ctrl_sel, tgt_we}, 32'h0);
    init_req = 1'b0;
    rst_n    = 1'b1;
    repeat (4) @(negedge clk);
    check({host_busy, host_rvalid, host_err, core_sel, dma_sel, ctrl_sel, tgt_we} === 7'b0,
          "R11", "outputs after reset",
          {25'b0, host_busy, host_rvalid, host_err, core_sel, dma_sel, ctrl_sel, tgt_we}, 32'h0);
    check_mems("R11");

    // R1 core words, full width and narrow lanes (R6)
    access(1'b1, 8'h0C, 2, 32'h1122_3344, "R1");
    access(1'b0, 8'h0C, 2, 32'h0, "R1");
    access(1'b1, 8'h0D, 0, 32'hFFFF_FF5A, "R6");
    for (int off = 0; off < 4; off++) access(1'b0, 8'h0C + off, 0, 32'h0, "R1");
    access(1'b0, 8'h0E, 1, 32'h0, "R1");
    access(1'b1, 8'h02, 1, 32'h0000_C0DE, "R6");
    access(1'b1, 8'h3F, 0, 32'h0000_0077, "R6");
    access(1'b0, 8'h3C, 2, 32'h0, "R1");

    // R2 DMA bank edges
    access(1'b1, 8'h42, 1, 32'h1234_BEEF, "R2");
    access(1'b0, 8'h40, 2, 32'h0, "R2");
    access(1'b0, 8'h42, 1, 32'h0, "R2");
    access(1'b1, 8'h5C, 2, 32'hCAFE_F00D, "R2");
    access(1'b0, 8'h5F, 0, 32'h0, "R2");

    // R3 control word only at exactly 0x70
    access(1'b1, 8'h70, 2, 32'hA1B2_C3D4, "R3");
    access(1'b0, 8'h70, 2, 32'h0, "R3");
    access(1'b0, 8'h71, 0, 32'h0, "R3");
    access(1'b0, 8'h72, 1, 32'h0, "R3");
    access(1'b1, 8'h72, 0, 32'h0000_0099, "R3");
    access(1'b1, 8'h70, 0, 32'h0000_0066, "R3");
    access(1'b0, 8'h70, 2, 32'h0, "R3");

    // R4 unmapped offsets
    access(1'b0, 8'h60, 2, 32'h0, "R4");
    access(1'b0, 8'h7C, 2, 32'h0, "R4");
    access(1'b1, 8'h64, 2, 32'hDEAD_BEEF, "R4");
    access(1'b1, 8'h75, 0, 32'h0000_0011, "R4");
    access(1'b0, 8'h6E, 1, 32'h0, "R4");

    // R8 boundary-crossing and R5 reserved size
    access(1'b1, 8'h03, 1, 32'h0000_5555, "R8");
    access(1'b1, 8'h42, 2, 32'h7777_7777, "R8");
    access(1'b0, 8'h3F, 1, 32'h0, "R8");
    access(1'b1, 8'h10, 3, 32'h3333_3333, "R5");
    access(1'b0, 8'h10, 3, 32'h0, "R5");

    // R10 a second request during a merge is ignored
    host_req   = 1'b1;
    host_we    = 1'b1;
    host_addr  = 7'h05;
    host_size  = 2'd0;
    host_wdata = 32'h0000_00AB;
    @(negedge clk);
    host_addr  = 7'h00;
    host_size  = 2'd2;
    host_wdata = 32'hDEAD_BEEF;
    check(host_busy === 1'b1, "R10", "busy in fetch", {31'b0, host_busy}, 32'h1);
    @(negedge clk);
    check(host_busy === 1'b1, "R10", "busy in write", {31'b0, host_busy}, 32'h1);
    host_req = 1'b0;
    @(negedge clk);
    check(host_busy === 1'b0, "R10", "idle after merge", {31'b0, host_busy}, 32'h0);
    mdl_write(5, 1, 32'h0000_00AB);
    check_mems("R10");

    // mixed traffic against the model
    for (int t = 0; t < 300; t++) begin
      a    = $urandom_range(0, 127);
      r    = $urandom_range(0, 9);
      code = (r < 3) ? 0 : (r < 6) ? 1 : (r < 9) ? 2 : 3;
      we   = 1'($urandom_range(0, 1));
      access(we, a, code, $urandom, we ? "R6" : region_tag(a));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule